// File: doc/BRIEF.md
# Bit-Banged I2C Serial EEPROM Slave

This block models a 256-byte (or 128-byte) serial EEPROM that sits behind a software-driven two-wire bus. A host does not drive real pins. Each time it writes its clock/data register, it raises a one-cycle sample strobe together with the new SCL and SDA levels. On every strobe the slave compares the new levels with the levels it stored last time. From that comparison it recognises start and stop conditions and rising clock edges. It then updates a single bit-position counter, which walks it through a command byte, an acknowledge, an address byte and a second acknowledge.

The returned SDA level is what the host reads back. It is the host's own level ANDed with the slave's pull-down. The slave pulls low in acknowledge slots. During the address phase of a read command, it also pulls low wherever the outgoing data bit is 0.

The byte fetched at the end of one address phase is shifted out, most significant bit first, during the address phase of the next read transaction. The contents are fixed at build time from a parameter image.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the returned SDA (`sda_rd`) is 1 and the slave is idle.
- R2: While idle (bit counter 0, no acknowledge pending), clock edges and data bits have no effect, and no acknowledge is ever returned.
- R3: SDA falling while SCL is high both before and after the strobe is a start. It sets the bit counter to 1 and clears the command byte. The next eight sampled bits form the command byte, first bit ending as the MSB.
- R4: A rising SCL edge is sampled only if SDA is unchanged on the same strobe. An edge where SDA also changes is not counted.
- R5: The rising SCL edge that follows the eighth bit of the command byte or of the address byte is an acknowledge slot. It returns SDA 0 and is not sampled as data.
- R6: After the command acknowledge, eight more sampled bits form the address byte, and a second acknowledge follows them.
- R7: If bit 0 of the command byte is 1 (read), each address-phase edge returns the MSB of the data register, and the data register then shifts left by one.
- R8: On the eighth address bit, the data register loads memory byte (address mod DEPTH). With the default image, byte i holds (37·i + 0x5A) mod 256. The counter returns to 0 with an acknowledge pending.
- R9: SDA rising while SCL stays high is a stop. It returns the slave to idle and clears any pending acknowledge.
- R10: The returned SDA is the host's SDA ANDed with the slave's pull-down. When the slave is not pulling, it equals the last sampled host SDA.
- R11: Cycles with `smp_en` low change neither the returned SDA nor the protocol state.
- R12: With DEPTH = 128, only the low seven address bits select the byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | One-cycle strobe: host wrote new bus levels |
| scl_wr | input | 1 | SCL level written by the host |
| sda_wr | input | 1 | SDA level written by the host |
| sda_rd | output | 1 | Registered returned SDA level (open-drain combination) |

## Verification
A 256-byte and a 128-byte instance receive identical bus traffic, and both are compared on every strobe against a behavioural bit-level model.

The patterns are:
- clocking without a start, to separate idle from armed;
- a start followed by a clock edge that moves SDA together with SCL, so that a miscounted edge shifts the acknowledge by one slot;
- a stop placed where an acknowledge is pending, to show the stop clears it;
- a write-then-read pair at address 0x83, which tells the two depths apart through address truncation;
- a read with the host holding SDA low, to expose the open-drain AND;
- bus levels changed with the strobe held low, which must leave no trace.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 256;
  localparam int TICK_W    = 5;
  localparam logic [TICK_W-1:0] CMD_END  = TICK_W'(9);
  localparam logic [TICK_W-1:0] ADDR_END = TICK_W'(17);

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic logic [MAX_BYTES*BYTE_W-1:0] default_image(input byte_t seed);
    logic [MAX_BYTES*BYTE_W-1:0] img;
    img = '0;
    for (int i = 0; i < MAX_BYTES; i++) begin
      img[i*BYTE_W +: BYTE_W] = byte_t'(i * 37 + int'(seed));
    end
    return img;
  endfunction
endpackage

// File: rtl/i2c_eeprom_cond.sv
module i2c_eeprom_cond (
  input  logic scl_q,
  input  logic sda_q,
  input  logic scl_i,
  input  logic sda_i,
  output logic is_cond,
  output logic is_rise,
  output logic is_steady
);
  // SCL high on both sides with SDA moving: start or stop
  assign is_cond   = scl_q & scl_i & (sda_q ^ sda_i);
  assign is_rise   = ~scl_q & scl_i;
  assign is_steady = ~(sda_q ^ sda_i);
endmodule

// File: rtl/i2c_eeprom_rom.sv
module i2c_eeprom_rom
  import i2c_eeprom_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter logic [MAX_BYTES*BYTE_W-1:0] IMAGE = '0
) (
  input  logic [AW-1:0] addr,
  output byte_t         dout
);
  byte_t words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign words[g] = IMAGE[g*BYTE_W +: BYTE_W];
  end

  assign dout = words[addr];
endmodule

// File: rtl/i2c_eeprom_seq.sv
module i2c_eeprom_seq
  import i2c_eeprom_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          is_cond,
  input  logic          is_rise,
  input  logic          is_steady,
  input  byte_t         rom_byte,
  output logic [AW-1:0] rom_addr,
  output logic          scl_q,
  output logic          sda_q
);
  logic [TICK_W-1:0] tick_q, n_tick;
  logic              ack_q, n_ack;
  byte_t             cmd_q, n_cmd;
  byte_t             data_q, n_data;
  logic [AW-1:0]     addr_q, n_addr;
  logic              n_sda;
  logic              idle;

  assign idle     = (tick_q == '0) && !ack_q;
  assign rom_addr = {addr_q[AW-2:0], sda_i};

  always_comb begin
    n_tick = tick_q;
    n_ack  = ack_q;
    n_cmd  = cmd_q;
    n_data = data_q;
    n_addr = addr_q;
    n_sda  = sda_i;
    if (is_cond) begin
      if (!sda_i) begin
        n_tick = TICK_W'(1);
        n_cmd  = '0;
      end else begin
        n_tick = '0;
        n_ack  = 1'b0;
      end
    end else if (idle) begin
      n_tick = tick_q;
    end else if (is_rise) begin
      if (ack_q) begin
        n_sda = 1'b0;
        n_ack = 1'b0;
      end else if (is_steady) begin
        if (tick_q < CMD_END) begin
          n_cmd  = {cmd_q[BYTE_W-2:0], sda_i};
          n_tick = tick_q + TICK_W'(1);
          if (tick_q == CMD_END - TICK_W'(1)) n_ack = 1'b1;
        end else begin
          if (cmd_q[0]) n_sda = sda_i & data_q[BYTE_W-1];
          n_addr = rom_addr;
          if (tick_q == ADDR_END - TICK_W'(1)) begin
            n_data = rom_byte;
            n_ack  = 1'b1;
            n_tick = '0;
          end else begin
            n_data = {data_q[BYTE_W-2:0], 1'b0};
            n_tick = tick_q + TICK_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      ack_q  <= 1'b0;
      cmd_q  <= '0;
      data_q <= '0;
      addr_q <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else if (en) begin
      tick_q <= n_tick;
      ack_q  <= n_ack;
      cmd_q  <= n_cmd;
      data_q <= n_data;
      addr_q <= n_addr;
      scl_q  <= scl_i;
      sda_q  <= n_sda;
    end
  end

  a_r3_start_arms: assert property (@(posedge clk) disable iff (rst)
    (en && is_cond && !sda_i) |=> (tick_q == TICK_W'(1) && cmd_q == '0));
  a_r9_stop_idles: assert property (@(posedge clk) disable iff (rst)
    (en && is_cond && sda_i) |=> (tick_q == '0 && !ack_q));
  a_r5_ack_low: assert property (@(posedge clk) disable iff (rst)
    (en && !is_cond && is_rise && ack_q) |=> (!sda_q && !ack_q));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(sda_q) && $stable(tick_q) && $stable(data_q)));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (en && !is_cond && tick_q == '0 && !ack_q) |=> (tick_q == '0 && !ack_q));
  a_r6_tick_bound: assert property (@(posedge clk) disable iff (rst)
    tick_q < ADDR_END);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eeprom_pkg::*;
#(
  parameter int    DEPTH = 256,
  parameter byte_t SEED  = 8'h5A,
  parameter logic [MAX_BYTES*BYTE_W-1:0] IMAGE = default_image(SEED)
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_en,
  input  logic scl_wr,
  input  logic sda_wr,
  output logic sda_rd
);
  localparam int AW = $clog2(DEPTH);

  logic          scl_q, sda_q;
  logic          is_cond, is_rise, is_steady;
  logic [AW-1:0] rom_addr;
  byte_t         rom_byte;

  i2c_eeprom_cond u_cond (
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_i     (scl_wr),
    .sda_i     (sda_wr),
    .is_cond   (is_cond),
    .is_rise   (is_rise),
    .is_steady (is_steady)
  );

  i2c_eeprom_rom #(.DEPTH(DEPTH), .AW(AW), .IMAGE(IMAGE)) u_rom (
    .addr (rom_addr),
    .dout (rom_byte)
  );

  i2c_eeprom_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (smp_en),
    .scl_i     (scl_wr),
    .sda_i     (sda_wr),
    .is_cond   (is_cond),
    .is_rise   (is_rise),
    .is_steady (is_steady),
    .rom_byte  (rom_byte),
    .rom_addr  (rom_addr),
    .scl_q     (scl_q),
    .sda_q     (sda_q)
  );

  assign sda_rd = sda_q;

  // R10: returned line never high while the host drove it low
  a_r10_wired_and: assert property (@(posedge clk) disable iff (rst)
    (smp_en && !sda_wr) |=> !sda_rd);
endmodule

// File: tb/test_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module test_i2c_eeprom_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic rd0, rd1;
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  int m_scl[2], m_sda[2], m_tick[2], m_ack[2], m_cmd[2], m_addr[2], m_data[2];
  int depth[2] = '{256, 128};

  always #2 clk = ~clk;

  i2c_eeprom_slave i_i2c_eeprom_slave (
    .clk(clk), .rst(rst), .smp_en(en), .scl_wr(scl), .sda_wr(sda), .sda_rd(rd0));
  i2c_eeprom_slave #(.DEPTH(128)) i_i2c_eeprom_slave_d128 (
    .clk(clk), .rst(rst), .smp_en(en), .scl_wr(scl), .sda_wr(sda), .sda_rd(rd1));

  function automatic int exp_byte(int a, int dep);
    return ((a % dep) * 37 + 'h5A) % 256;
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int k = 0; k < 2; k++) begin
      m_scl[k] = 1; m_sda[k] = 1; m_tick[k] = 0; m_ack[k] = 0;
      m_cmd[k] = 0; m_addr[k] = 0; m_data[k] = 0;
    end
  endtask

  task automatic m_step(int k, int s, int d);
    int nd = d;
    if (m_scl[k] == 1 && s == 1 && m_sda[k] != d) begin
      if (d == 0) begin m_tick[k] = 1; m_cmd[k] = 0; end
      else begin m_tick[k] = 0; m_ack[k] = 0; end
    end else if (m_tick[k] == 0 && m_ack[k] == 0) begin
      nd = d;
    end else if (m_scl[k] == 0 && s == 1) begin
      if (m_ack[k] != 0) begin
        nd = 0; m_ack[k] = 0;
      end else if (m_sda[k] == d) begin
        if (m_tick[k] < 9) begin
          m_cmd[k] = ((m_cmd[k] << 1) | d) & 255;
          m_tick[k]++;
          if (m_tick[k] == 9) m_ack[k] = 1;
        end else begin
          if ((m_cmd[k] & 1) != 0) nd = d & ((m_data[k] >> 7) & 1);
          m_addr[k] = ((m_addr[k] << 1) | d) & 255;
          m_data[k] = (m_data[k] << 1) & 255;
          m_tick[k]++;
          if (m_tick[k] == 17) begin
            m_data[k] = exp_byte(m_addr[k], depth[k]);
            m_ack[k] = 1; m_tick[k] = 0;
          end
        end
      end
    end
    m_scl[k] = s; m_sda[k] = nd;
  endtask

  task automatic put(int s, int d, string tag);
    @(negedge clk);
    scl = s[0]; sda = d[0]; en = 1'b1;
    for (int k = 0; k < 2; k++) m_step(k, s, d);
    @(negedge clk);
    en = 1'b0;
    check({tag, " model"}, int'(rd0), m_sda[0]);
    check({tag, " model d128"}, int'(rd1), m_sda[1]);
  endtask

  task automatic send_bit(int b, string tag);
    put(0, b, tag); put(1, b, tag); put(0, b, tag);
  endtask

  task automatic send_byte(int v, string tag);
    for (int i = 7; i >= 0; i--) send_bit((v >> i) & 1, tag);
  endtask

  task automatic ack_slot(output int a0, output int a1);
    put(0, 1, "R5"); put(1, 1, "R5");
    a0 = int'(rd0); a1 = int'(rd1);
    put(0, 1, "R5");
  endtask

  task automatic read_byte(int mbits, output int b0, output int b1);
    b0 = 0; b1 = 0;
    for (int i = 7; i >= 0; i--) begin
      int mb = (mbits >> i) & 1;
      put(0, mb, "R7"); put(1, mb, "R7");
      b0 = (b0 << 1) | int'(rd0);
      b1 = (b1 << 1) | int'(rd1);
      put(0, mb, "R7");
    end
  endtask

  task automatic start_c();
    put(1, 1, "R3"); put(1, 0, "R3");
  endtask

  task automatic stop_c();
    put(0, 0, "R9"); put(1, 0, "R9"); put(1, 1, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int a0, a1, b0, b1;
    m_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset sda", int'(rd0), 1);
    check("R1 reset sda d128", int'(rd1), 1);

    // R2: clocking with no start
    for (int i = 0; i < 8; i++) send_bit(1, "R2");
    ack_slot(a0, a1);
    check("R2 no ack while idle", a0, 1);

    // R3/R5/R6: write command, address 0x83
    start_c();
    send_byte('hA0, "R3");
    ack_slot(a0, a1);
    check("R5 command ack", a0, 0);
    check("R5 command ack d128", a1, 0);
    send_byte('h83, "R6");
    ack_slot(a0, a1);
    check("R6 address ack", a0, 0);
    stop_c();

    // R7/R8/R12: read out byte loaded at 0x83
    start_c();
    send_byte('hA1, "R7");
    ack_slot(a0, a1);
    read_byte('hFF, b0, b1);
    check("R8 read data at 0x83", b0, exp_byte('h83, 256));
    check("R12 read data d128 (0x03)", b1, exp_byte('h83, 128));
    ack_slot(a0, a1);
    check("R8 ack after load", a0, 0);
    stop_c();

    // R10: host holds SDA low during read -> line low
    start_c();
    send_byte('hA1, "R10");
    ack_slot(a0, a1);
    read_byte('h00, b0, b1);
    check("R10 wired-AND low", b0, 0);
    check("R10 wired-AND low d128", b1, 0);
    ack_slot(a0, a1);
    stop_c();

    // R7: previous read loaded address 0xFF, then 0x00
    start_c();
    send_byte('hA1, "R7");
    ack_slot(a0, a1);
    read_byte('hFF, b0, b1);
    check("R7 read data at 0x00", b0, exp_byte(0, 256));
    ack_slot(a0, a1);
    stop_c();
    start_c();
    send_byte('hA1, "R7");
    ack_slot(a0, a1);
    read_byte('hFF, b0, b1);
    check("R7 read data at 0xFF", b0, exp_byte('hFF, 256));
    check("R12 read data d128 at 0x7F", b1, exp_byte('hFF, 128));
    ack_slot(a0, a1);
    stop_c();

    // R4: clock edge with SDA moving is not counted
    start_c();
    put(0, 0, "R4"); put(1, 1, "R4"); put(0, 1, "R4");
    send_byte('hA0, "R4");
    ack_slot(a0, a1);
    check("R4 ack position after glitch edge", a0, 0);
    stop_c();

    // R9: stop while acknowledge pending clears it
    start_c();
    for (int i = 7; i >= 1; i--) send_bit(('hA0 >> i) & 1, "R9");
    put(0, 0, "R9"); put(1, 0, "R9");
    put(1, 1, "R9");
    ack_slot(a0, a1);
    check("R9 stop cleared pending ack", a0, 1);

    // R11: would-be start with strobe low is ignored
    @(negedge clk);
    scl = 1'b1; sda = 1'b0; en = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 held output", int'(rd0), 1);
    for (int i = 0; i < 8; i++) send_bit(0, "R11");
    ack_slot(a0, a1);
    check("R11 no start registered", a0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule